// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is a 4 KB register frame on a simple 32-bit register bus. A device signals an interrupt by writing an interrupt ID to the frame's doorbell word. The frame subtracts a fixed offset from that ID, which is the base interrupt number plus 32. If the result falls inside the configured bank, the frame raises a one-clock pulse on the matching wired interrupt line. The frame also exposes a read-only type word, which tells software the first ID and the number of lines. An identification word and a zero-filled ID space complete the read side.

Every access is sampled on the clock edge where its strobe is seen. Read data, the error strobe and the interrupt pulses all appear in the cycle that follows. The error strobe marks an access of an illegal width, an access to an offset the frame does not decode, or a read and a write issued together. Data ordering is little-endian, and byte offsets are the full 12-bit address. The parameters `BASE_SPI` and `NUM_LINES` set the ID offset and the bank size, and they are checked against their limits at elaboration.

Top module: `msi_pulse_frame`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq_pulse`, `bus_err` and `bus_rdata` are all zero.
- R2: A 4-byte read of offset 0x008 returns ((BASE_SPI+32) << 16) | NUM_LINES on `bus_rdata` in the cycle after the read strobe, and `bus_err` stays low.
- R3: A 4-byte read of offset 0xFCC returns 0x0510_0000 (the value 0x51 at bit 20, all other fields zero) in the next cycle, and `bus_err` stays low.
- R4: A 4-byte read of any offset from 0xFD0 to 0xFFC inclusive returns zero, and `bus_err` stays low.
- R5: A write of size 2 or 4 to offset 0x040 takes the ID from `bus_wdata[9:0]` and computes index = ID − (BASE_SPI+32). If 0 ≤ index < NUM_LINES, bit `irq_pulse[index]` is high in the next cycle only, and no other bit is high.
- R6: A doorbell write whose ID is outside the range of R5 raises no pulse and no error. Data bits above bit 9 never affect which line is selected.
- R7: Each accepted doorbell write gives its own high cycle. Two writes to the same line on consecutive cycles hold that line high for two cycles. Writes separated by an idle cycle give two distinct pulses.
- R8: A read of any size other than 4, or a write of any size other than 2 or 4, raises `bus_err` for one cycle. Such a read returns zero, and such a write pulses no line. Sizes are given in bytes on `bus_size`.
- R9: An access to an offset the frame does not decode raises `bus_err` for one cycle. A read there returns zero, and a write there pulses no line. The decoded offsets are 0x008, 0xFCC and 0xFD0–0xFFC for reads, and 0x040 for writes.
- R10: A read strobe and a write strobe in the same cycle raise `bus_err`, load zero into `bus_rdata`, and pulse no line.
- R11: `bus_rdata` keeps its last value in every cycle that follows a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error strobe for a rejected access |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses, one bit per line |

## Verification
The bench builds the frame with BASE_SPI = 100 and NUM_LINES = 20, which makes the accepted ID window 132 to 151. Both sides of that window can then be reached with IDs that are ordinary for a 10-bit field. Writing 131, 152, zero and 1023 probes the lower and upper edges of the subtraction. With a non-zero base, a type word whose offset field is wrong, or a doorbell that forgets the bias of 32, gives a value that differs from the expected one.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;
  localparam int SIZE_W = 3;

  localparam int ID_BIAS    = 32;
  localparam int LINE_CAP   = 128;
  localparam int ID_CEILING = 1020;

  localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_ZERO_LO  = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFS_ZERO_HI  = 12'hFFC;

  localparam logic [DATA_W-1:0] IDENT_WORD = 32'h0510_0000;

  typedef enum logic [1:0] {
    RSEL_ZERO  = 2'd0,
    RSEL_TYPE  = 2'd1,
    RSEL_IDENT = 2'd2
  } rsel_e;

  typedef struct packed {
    logic  rd_ok;
    logic  wr_ok;
    logic  reject;
    rsel_e rsel;
  } acc_t;
endpackage

// File: rtl/mpf_access_decode.sv
module mpf_access_decode
  import mpf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [SIZE_W-1:0] size,
  output acc_t              acc
);
  logic lone_rd, lone_wr;
  logic rd_size_ok, wr_size_ok;
  logic hit_type, hit_ident, hit_zero, hit_bell;

  always_comb begin
    lone_rd    = rd & ~wr;
    lone_wr    = wr & ~rd;
    rd_size_ok = (size == SIZE_W'(4));
    wr_size_ok = (size == SIZE_W'(2)) || (size == SIZE_W'(4));
    hit_type   = (addr == OFS_TYPE);
    hit_ident  = (addr == OFS_IDENT);
    hit_zero   = (addr >= OFS_ZERO_LO) && (addr <= OFS_ZERO_HI);
    hit_bell   = (addr == OFS_DOORBELL);

    acc.rd_ok  = lone_rd & rd_size_ok & (hit_type | hit_ident | hit_zero);
    acc.wr_ok  = lone_wr & wr_size_ok & hit_bell;
    acc.reject = (rd | wr) & ~acc.rd_ok & ~acc.wr_ok;

    if (hit_type)       acc.rsel = RSEL_TYPE;
    else if (hit_ident) acc.rsel = RSEL_IDENT;
    else                acc.rsel = RSEL_ZERO;
  end
endmodule

// File: rtl/mpf_doorbell.sv
module mpf_doorbell
  import mpf_pkg::*;
#(
  parameter int BASE_SPI  = 0,
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [ID_W-1:0]      id,
  output logic [NUM_LINES-1:0] irq_pulse
);
  localparam int FIRST_ID = BASE_SPI + ID_BIAS;
  localparam int IDX_W    = ID_W + 1;

  logic [IDX_W-1:0]     id_ext;
  logic [IDX_W-1:0]     idx;
  logic                 in_range;
  logic [NUM_LINES-1:0] pulse_nxt;
  logic [NUM_LINES-1:0] pulse_q;

  always_comb begin
    id_ext   = {1'b0, id};
    idx      = id_ext - IDX_W'(FIRST_ID);
    in_range = (id_ext >= IDX_W'(FIRST_ID)) && (idx < IDX_W'(NUM_LINES));
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb pulse_nxt[i] = fire & in_range & (idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_nxt;
  end

  assign irq_pulse = pulse_q;

  // R5: never more than one line per cycle
  assert_one_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));
  // R5/R7: any pulse traces back to an accepted doorbell write one cycle earlier
  assert_pulse_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> $past(fire));
  // R6: an accepted write with an ID outside the window leaves all lines low
  assert_out_of_range_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_range) |=> (irq_pulse == '0));
endmodule

// File: rtl/mpf_readback.sv
module mpf_readback
  import mpf_pkg::*;
#(
  parameter logic [DATA_W-1:0] TYPE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic              rd_ok,
  input  rsel_e             rsel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_nxt;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rdata_nxt = '0;
    if (rd_ok) begin
      unique case (rsel)
        RSEL_TYPE:  rdata_nxt = TYPE_WORD;
        RSEL_IDENT: rdata_nxt = IDENT_WORD;
        default:    rdata_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_strobe) rdata_q <= rdata_nxt;
  end

  assign rdata = rdata_q;

  // R11: data holds when no read was presented
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_strobe) |-> $stable(rdata));
  // R8/R9/R10: a refused read loads zero
  assert_refused_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_ok) |=> (rdata == '0));
endmodule

// File: rtl/msi_pulse_frame.sv
module msi_pulse_frame
  import mpf_pkg::*;
#(
  parameter int BASE_SPI  = 0,
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [2:0]           bus_size,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_LINES-1:0] irq_pulse
);
  localparam int FIRST_ID = BASE_SPI + ID_BIAS;
  localparam logic [DATA_W-1:0] TYPE_WORD =
    (DATA_W'(FIRST_ID) << 16) | DATA_W'(NUM_LINES);

  initial begin
    assert (NUM_LINES >= 1 && NUM_LINES <= LINE_CAP && BASE_SPI >= 0 &&
            FIRST_ID + NUM_LINES <= ID_CEILING)
      else $fatal(1, "msi_pulse_frame: parameters outside the supported range");
  end

  acc_t acc;
  logic err_nxt;
  logic err_q;

  mpf_access_decode u_decode (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .size (bus_size),
    .acc  (acc)
  );

  mpf_doorbell #(
    .BASE_SPI  (BASE_SPI),
    .NUM_LINES (NUM_LINES)
  ) u_doorbell (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (acc.wr_ok),
    .id        (bus_wdata[ID_W-1:0]),
    .irq_pulse (irq_pulse)
  );

  mpf_readback #(
    .TYPE_WORD (TYPE_WORD)
  ) u_readback (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (bus_rd),
    .rd_ok     (acc.rd_ok),
    .rsel      (acc.rsel),
    .rdata     (bus_rdata)
  );

  always_comb err_nxt = acc.reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_nxt;
  end

  assign bus_err = err_q;

  // R8/R9: an error only follows a presented access
  assert_err_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_wr || bus_rd));
  // R10: colliding strobes are refused and pulse nothing
  assert_collision_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> (bus_err && irq_pulse == '0));
  // R8: an error cycle never carries an interrupt pulse
  assert_err_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (irq_pulse == '0));
endmodule

// File: tb/msi_pulse_frame_tb.sv
module msi_pulse_frame_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 100;
  localparam int LINES      = 20;
  localparam int FIRST      = BASE + 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [11:0]      bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [2:0]       bus_size = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_err;
  logic [LINES-1:0] irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] rdata_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_pulse_frame #(.BASE_SPI(BASE), .NUM_LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [2:0] s,
                                           output bit err);
    err = 1'b0;
    if (s != 3'd4) begin err = 1'b1; return 0; end
    if (a == 12'h008) return (32'(FIRST) << 16) | 32'(LINES);
    if (a == 12'hFCC) return 32'h0510_0000;
    if (a >= 12'hFD0 && a <= 12'hFFC) return 0;
    err = 1'b1;
    return 0;
  endfunction

  function automatic logic [LINES-1:0] exp_write(input logic [11:0] a, input logic [2:0] s,
                                                 input logic [31:0] d, output bit err);
    int id;
    logic [LINES-1:0] v = '0;
    err = 1'b0;
    if ((s != 3'd2 && s != 3'd4) || a != 12'h040) begin err = 1'b1; return v; end
    id = int'(d[9:0]);
    if (id >= FIRST && id < FIRST + LINES) v[id - FIRST] = 1'b1;
    return v;
  endfunction

  // one bus cycle; outputs are compared on the following falling edge
  task automatic op(input string tag, input bit w, input bit r, input logic [11:0] a,
                    input logic [2:0] s, input logic [31:0] d);
    bit e_err = 1'b0;
    logic [LINES-1:0] e_irq = '0;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_size = s; bus_wdata = d;
    if (w && r) begin
      e_err = 1'b1; rdata_model = '0;
    end else if (r) begin
      rdata_model = exp_read(a, s, e_err);
    end else if (w) begin
      e_irq = exp_write(a, s, d, e_err);
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk({tag, " err"},   32'(bus_err),   32'(e_err));
    chk({tag, " irq"},   32'(irq_pulse), 32'(e_irq));
    chk({tag, " rdata"}, bus_rdata,      rdata_model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset irq",   32'(irq_pulse), 0);
    chk("R1 reset err",   32'(bus_err),   0);
    chk("R1 reset rdata", bus_rdata,      0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset irq", 32'(irq_pulse), 0);

    op("R2 type word",  0, 1, 12'h008, 3'd4, 0);
    op("R11 hold",      0, 0, 12'h008, 3'd4, 0);
    op("R3 ident word", 0, 1, 12'hFCC, 3'd4, 0);
    op("R4 zero lo",    0, 1, 12'hFD0, 3'd4, 0);
    op("R4 zero hi",    0, 1, 12'hFFC, 3'd4, 0);
    op("R9 past zero",  0, 1, 12'hFFD, 3'd4, 0);
    op("R5 first id",   1, 0, 12'h040, 3'd4, 32'd132);
    op("R5 pulse ends", 0, 0, 12'h000, 3'd0, 0);
    op("R5 last id h",  1, 0, 12'h040, 3'd2, 32'd151);
    op("R6 below",      1, 0, 12'h040, 3'd4, 32'd131);
    op("R6 above",      1, 0, 12'h040, 3'd4, 32'd152);
    op("R6 zero id",    1, 0, 12'h040, 3'd4, 32'd0);
    op("R6 max id",     1, 0, 12'h040, 3'd4, 32'd1023);
    op("R6 high bits",  1, 0, 12'h040, 3'd4, 32'hFFFF_FC8A);
    op("R7 b2b a",      1, 0, 12'h040, 3'd4, 32'd140);
    op("R7 b2b b",      1, 0, 12'h040, 3'd4, 32'd140);
    op("R7 gap",        0, 0, 12'h000, 3'd0, 0);
    op("R7 again",      1, 0, 12'h040, 3'd4, 32'd140);
    op("R8 rd size2",   0, 1, 12'h008, 3'd2, 0);
    op("R8 wr size1",   1, 0, 12'h040, 3'd1, 32'd140);
    op("R8 wr size3",   1, 0, 12'h040, 3'd3, 32'd140);
    op("R9 wr type",    1, 0, 12'h008, 3'd4, 32'd140);
    op("R9 rd bell",    0, 1, 12'h040, 3'd4, 0);
    op("R2 reload",     0, 1, 12'h008, 3'd4, 0);
    op("R10 collide",   1, 1, 12'h040, 3'd4, 32'd140);

    for (int k = 0; k < 400; k++) begin
      int kind = int'($urandom % 8);
      logic [11:0] a;
      logic [2:0]  s = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd4 : 3'd2);
      logic [31:0] d = {$urandom, 10'd0} | 32'(120 + $urandom % 45);
      case (kind)
        0, 1, 2: op("R5 rand bell", 1, 0, 12'h040, s, d);
        3: begin a = 12'h008; op("R2 rand rd", 0, 1, a, s, 0); end
        4: begin a = 12'hFD0 + 12'(4 * ($urandom % 12)); op("R4 rand rd", 0, 1, a, s, 0); end
        5: begin a = 12'($urandom); op("R9 rand rd", 0, 1, a, s, 0); end
        6: begin a = 12'($urandom); op("R9 rand wr", 1, 0, a, s, d); end
        default: op("R11 rand idle", 0, 0, 12'($urandom), s, d);
      endcase
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule